// File: doc/BRIEF.md
# SPI Transmit Queue Write Port

This block is the slave-side write path of a serial peripheral interface that feeds a 64-byte transmit queue. A host selects the device with an active-low select line and clocks bytes in, most significant bit first. The first byte of each transaction is a command byte. Bit 7 is the direction bit, and 0 means write. Bit 6 is the burst flag. Bits 5:0 carry an address. Only a write to address 0x3F reaches the queue.

A single-byte command takes exactly one data byte. The next byte is then read as a fresh command. A burst command keeps storing data bytes until the select line is released. While each byte is shifted in, the block shifts out a status byte. This status byte reports the radio state and how much room the queue had before the current byte went in.

A downstream consumer drains the queue through a simple pop interface. The queue can be flushed on request, but only in states where that is safe. It is also emptied whenever the radio state enters sleep. The serial lines are synchronised into the system clock, and their edges are detected there. The system clock must run several times faster than the serial clock.

Top module: `txq_spi_port`

## Requirements
- R1: A command byte with bit 7 = 0 and bits 5:0 = 0x3F opens a queue write. Bit 6 = 0 (byte 0x3F) selects a single write and bit 6 = 1 (byte 0x7F) selects a burst write.
- R2: After a single write, exactly one data byte is stored. The byte after it is decoded as a new command byte while select stays low.
- R3: After a burst command, every following byte is stored in order until select goes high.
- R4: A command byte with bit 7 = 1, or with an address other than 0x3F, makes the rest of that transaction store nothing.
- R5: During every byte, including command bytes, a status byte is shifted out MSB first. Its layout is bit 7 = 0, bits 6:4 = radio_state, and bits 3:0 = free entries saturated to 15. The free count is taken before the byte being received is stored.
- R6: While the 64th byte is being received into an empty queue, the status reports exactly one free entry.
- R7: A data byte that arrives while the queue is full is dropped, and `overflow` is set and stays set.
- R8: A pulse on `flush_req` empties the queue and clears `overflow` when radio_state is idle (code 0) or transmit-underflow (code 7). In any other state the pulse has no effect.
- R9: When radio_state changes to sleep (code 1), the queue is emptied and `overflow` is cleared.
- R10: `pop_valid` is high while the queue holds data, and `pop_data` shows the oldest byte. A cycle with `pop_ack` high removes that byte, so bytes leave in arrival order.
- R11: The serial mode is mode 0: MOSI is sampled on the rising serial clock and MISO changes on the falling one. `spi_miso` is low while select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial status data to the host |
| radio_state | input | 3 | Current radio state code (0 idle, 1 sleep, 2 transmit, 7 transmit underflow) |
| flush_req | input | 1 | One-cycle request to empty the queue |
| pop_ack | input | 1 | Consumer removes the oldest byte |
| pop_valid | output | 1 | Queue is not empty |
| pop_data | output | 8 | Oldest queued byte |
| overflow | output | 1 | Sticky flag: a byte was dropped because the queue was full |

## Verification
The hardest condition to reach from the ports is the queue boundary. That means the status seen on the 64th byte, the byte dropped just after it, and a flush refused while the queue is still full. A directed 65-byte burst into an empty queue reaches this condition. A refused flush follows in the transmit state, and an accepted one follows in the underflow state. The same fill is repeated before a sleep entry. Seeded random frames then mix single and burst writes, pops, state changes and flushes. This exercises the status byte at many fill levels against a queue model kept in the bench.

// File: rtl/txq_pkg.sv
// Shared definitions for the SPI transmit queue write port.
// Assumes radio state codes are supplied by an external state machine.
package txq_pkg;
    localparam logic [2:0] ST_IDLE  = 3'd0;
    localparam logic [2:0] ST_SLEEP = 3'd1;
    localparam logic [2:0] ST_TX    = 3'd2;
    localparam logic [2:0] ST_TXUF  = 3'd7;

    typedef enum logic [1:0] {
        PH_HDR    = 2'd0,
        PH_SINGLE = 2'd1,
        PH_BURST  = 2'd2,
        PH_SKIP   = 2'd3
    } phase_t;

    // Status byte: ready bit low, state code, saturated free count.
    function automatic logic [7:0] status_byte(input logic [2:0] st,
                                               input logic [3:0] free_sat);
        return {1'b0, st, free_sat};
    endfunction
endpackage

// File: rtl/txq_spi_sync.sv
// Brings the serial lines into the system clock domain and detects the serial
// clock edges. Assumes the system clock is several times faster than the
// serial clock, and that STAGES is at least 2.
module txq_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_active,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sclk_q;
    logic [TOP:0] cs_q;
    logic [TOP:0] mosi_q;
    logic         sclk_d;

    // Synchroniser chains plus one delayed copy of the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_q <= {sclk_q[TOP-1:0], sclk_in};
            cs_q   <= {cs_q[TOP-1:0], cs_n_in};
            mosi_q <= {mosi_q[TOP-1:0], mosi_in};
            sclk_d <= sclk_q[TOP];
        end
    end

    assign sclk_rise = sclk_q[TOP] & ~sclk_d;
    assign sclk_fall = ~sclk_q[TOP] & sclk_d;
    assign cs_active = ~cs_q[TOP];
    assign mosi_s    = mosi_q[TOP];
endmodule

// File: rtl/txq_spi_frame.sv
// Byte framing for mode-0 SPI. It shifts in bytes, decodes the command byte,
// issues one write pulse per stored data byte and shifts out a status byte
// for every byte. Assumes synchronised inputs and edge strobes from
// txq_spi_sync.
module txq_spi_frame
    import txq_pkg::*;
#(
    parameter logic [5:0] FIFO_ADDR = 6'h3F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_rise,
    input  logic       sclk_fall,
    input  logic       cs_active,
    input  logic       mosi_s,
    input  logic [2:0] radio_state,
    input  logic [3:0] free_sat,
    output logic       spi_miso,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    logic [6:0] rx_sh;
    logic [2:0] bit_cnt;
    logic [7:0] tx_sh;
    phase_t     phase;
    logic [7:0] byte_in;
    logic       byte_done;
    logic       hdr_hit;
    logic [7:0] status_now;

    // Assemble the incoming byte and decode the command fields.
    always_comb begin
        byte_in    = {rx_sh, mosi_s};
        byte_done  = cs_active && sclk_rise && (bit_cnt == 3'd7);
        hdr_hit    = !byte_in[7] && (byte_in[5:0] == FIFO_ADDR);
        status_now = status_byte(radio_state, free_sat);
    end

    // Receive side: shift MOSI, count bits, follow the frame phase, pulse writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
            phase   <= PH_HDR;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (!cs_active) begin
                bit_cnt <= '0;
                phase   <= PH_HDR;
            end else if (sclk_rise) begin
                rx_sh   <= byte_in[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_HDR:
                            phase <= hdr_hit ? (byte_in[6] ? PH_BURST : PH_SINGLE) : PH_SKIP;
                        PH_SINGLE: begin
                            wr_en   <= 1'b1;
                            wr_data <= byte_in;
                            phase   <= PH_HDR;
                        end
                        PH_BURST: begin
                            wr_en   <= 1'b1;
                            wr_data <= byte_in;
                        end
                        default: phase <= PH_SKIP;
                    endcase
                end
            end
        end
    end

    // Transmit side: reload status at each byte boundary, else shift left on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh <= '0;
        end else if (!cs_active) begin
            tx_sh <= status_now;
        end else if (sclk_fall) begin
            tx_sh <= (bit_cnt == 3'd0) ? status_now : {tx_sh[6:0], 1'b0};
        end
    end

    assign spi_miso = cs_active & tx_sh[7];

    // R2: a single write returns to command decoding after its data byte.
    a_r2_single_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_SINGLE) |=> (phase == PH_HDR));

    // R4: an ignored transaction never issues a write.
    a_r4_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SKIP) |-> !wr_en);

    // R1: writes are isolated one-cycle pulses.
    a_r1_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R11: bit counting restarts whenever select is released.
    a_r11_idle_realign: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_active |=> (bit_cnt == 3'd0 && phase == PH_HDR));
endmodule

// File: rtl/txq_fifo.sv
// Byte queue with a sticky overflow flag, a flush gated by the radio state and
// an automatic clear on sleep entry. Assumes DEPTH is a power of two of at
// least 16. Clearing takes priority over a write or pop in the same cycle.
module txq_fifo
    import txq_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       pop_ack,
    input  logic       flush_req,
    input  logic [2:0] radio_state,
    output logic       pop_valid,
    output logic [7:0] pop_data,
    output logic [3:0] free_sat,
    output logic       overflow
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] SAT  = CW'(15);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp;
    logic [AW-1:0] rp;
    logic [CW-1:0] count;
    logic [CW-1:0] free_cnt;
    logic          sleep_q;
    logic          sleep_entry;
    logic          flush_ok;
    logic          clr;
    logic          do_wr;
    logic          do_rd;

    // Decode clear sources and accepted accesses.
    always_comb begin
        sleep_entry = (radio_state == ST_SLEEP) && !sleep_q;
        flush_ok    = flush_req && ((radio_state == ST_IDLE) || (radio_state == ST_TXUF));
        clr         = flush_ok || sleep_entry;
        do_wr       = wr_en && (count != FULL);
        do_rd       = pop_ack && (count != '0);
        free_cnt    = FULL - count;
        free_sat    = (free_cnt > SAT) ? 4'hF : free_cnt[3:0];
    end

    // Storage array; holds no reset since contents are qualified by count.
    always_ff @(posedge clk) begin
        if (do_wr && !clr) mem[wp] <= wr_data;
    end

    // Pointers, occupancy, overflow flag and sleep-state history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            count    <= '0;
            overflow <= 1'b0;
            sleep_q  <= 1'b0;
        end else begin
            sleep_q <= (radio_state == ST_SLEEP);
            if (clr) begin
                wp       <= '0;
                rp       <= '0;
                count    <= '0;
                overflow <= 1'b0;
            end else begin
                if (do_wr) wp <= wp + 1'b1;
                if (do_rd) rp <= rp + 1'b1;
                count <= count + CW'(do_wr) - CW'(do_rd);
                if (wr_en && (count == FULL)) overflow <= 1'b1;
            end
        end
    end

    assign pop_valid = (count != '0);
    assign pop_data  = mem[rp];

    // R7: occupancy never exceeds the depth.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);

    // R7: a write into a full queue is dropped and flagged.
    a_r7_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && count == FULL && !pop_ack && !clr) |=> (count == FULL && overflow));

    // R8: an accepted flush leaves the queue empty with the flag clear.
    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush_ok |=> (count == '0 && !overflow));

    // R8: a flush in a disallowed state changes nothing.
    a_r8_flush_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && radio_state != ST_IDLE && radio_state != ST_TXUF &&
         radio_state != ST_SLEEP && !wr_en && !pop_ack) |=> ($stable(count) && $stable(overflow)));

    // R9: entering sleep empties the queue.
    a_r9_sleep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_entry |=> (count == '0 && !overflow));

    // R10: an accepted pop removes exactly one entry.
    a_r10_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ack && count != '0 && !wr_en && !clr) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/txq_spi_port.sv
// Top level of the SPI transmit queue write port. It joins the input
// synchroniser, the byte framer and the queue. Assumes the host uses mode 0
// and the system clock runs well above the serial clock rate.
module txq_spi_port
    import txq_pkg::*;
#(
    parameter int         DEPTH       = 64,
    parameter logic [5:0] FIFO_ADDR   = 6'h3F,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sclk,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [2:0] radio_state,
    input  logic       flush_req,
    input  logic       pop_ack,
    output logic       pop_valid,
    output logic [7:0] pop_data,
    output logic       overflow
);
    logic       sclk_rise;
    logic       sclk_fall;
    logic       cs_active;
    logic       mosi_s;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [3:0] free_sat;

    txq_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_in   (spi_sclk),
        .cs_n_in   (spi_cs_n),
        .mosi_in   (spi_mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_active (cs_active),
        .mosi_s    (mosi_s)
    );

    txq_spi_frame #(.FIFO_ADDR(FIFO_ADDR)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .cs_active   (cs_active),
        .mosi_s      (mosi_s),
        .radio_state (radio_state),
        .free_sat    (free_sat),
        .spi_miso    (spi_miso),
        .wr_en       (wr_en),
        .wr_data     (wr_data)
    );

    txq_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .pop_ack     (pop_ack),
        .flush_req   (flush_req),
        .radio_state (radio_state),
        .pop_valid   (pop_valid),
        .pop_data    (pop_data),
        .free_sat    (free_sat),
        .overflow    (overflow)
    );
endmodule

// File: tb/sim_txq_spi_port.sv
`timescale 1ns/1ps
module sim_txq_spi_port;
    import txq_pkg::*;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_mosi = 1'b0;
    logic       flush_req = 1'b0;
    logic       pop_ack = 1'b0;
    logic [2:0] radio_state = ST_IDLE;
    logic       spi_miso;
    logic       pop_valid;
    logic [7:0] pop_data;
    logic       overflow;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    logic [7:0] model [$];
    bit         ovf_m = 1'b0;

    always #2 clk = ~clk;

    txq_spi_port u0 (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .radio_state(radio_state),
        .flush_req(flush_req), .pop_ack(pop_ack), .pop_valid(pop_valid),
        .pop_data(pop_data), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected status from the requirement layout and the bench queue model.
    function automatic logic [7:0] exp_status();
        int fr = DEPTH - model.size();
        return {1'b0, radio_state, (fr > 15) ? 4'd15 : 4'(fr)};
    endfunction

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            tick(8);
            rx[i] = spi_miso;
            spi_sclk = 1'b1;
            tick(8);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic cs_begin();
        spi_cs_n = 1'b0;
        tick(8);
    endtask

    task automatic cs_end();
        tick(8);
        spi_cs_n = 1'b1;
        tick(8);
        chk(spi_miso == 1'b0, "R11", "miso while deselected", spi_miso, 0);
    endtask

    task automatic send_header(input logic [7:0] h);
        logic [7:0] rx;
        logic [7:0] e = exp_status();
        xfer(h, rx);
        chk(rx == e, "R5", "command byte status", rx, e);
    endtask

    task automatic send_data(input logic [7:0] d, input bit stores);
        logic [7:0] rx;
        logic [7:0] e = exp_status();
        xfer(d, rx);
        chk(rx == e, "R5", "data byte status", rx, e);
        if (stores) begin
            if (model.size() < DEPTH) model.push_back(d);
            else ovf_m = 1'b1;
        end
    endtask

    task automatic single_frame(input int n);
        cs_begin();
        for (int k = 0; k < n; k++) begin
            send_header(8'h3F);
            send_data(8'($urandom), 1'b1);   // R2 one data byte per command
        end
        cs_end();
    endtask

    task automatic burst_frame(input int n);
        cs_begin();
        send_header(8'h7F);
        for (int k = 0; k < n; k++) send_data(8'($urandom), 1'b1);   // R3
        cs_end();
    endtask

    task automatic pop_one();
        chk(pop_valid == 1'b1, "R10", "pop_valid", pop_valid, 1);
        chk(pop_data == model[0], "R10", "pop_data order", pop_data, model[0]);
        pop_ack = 1'b1;
        tick(1);
        pop_ack = 1'b0;
        void'(model.pop_front());
    endtask

    task automatic drain_check();
        while (model.size() > 0) pop_one();
        chk(pop_valid == 1'b0, "R10", "empty after drain", pop_valid, 0);
    endtask

    task automatic do_flush();
        flush_req = 1'b1;
        tick(1);
        flush_req = 1'b0;
        tick(2);
        if (radio_state == ST_IDLE || radio_state == ST_TXUF) begin
            model.delete();
            ovf_m = 1'b0;
        end
        chk(pop_valid == (model.size() != 0), "R8", "pop_valid after flush",
            pop_valid, int'(model.size() != 0));
        chk(overflow == ovf_m, "R8", "overflow after flush", overflow, ovf_m);
    endtask

    // Fill an empty queue with one burst, then push one byte too many.
    task automatic fill_overflow();
        logic [7:0] rx;
        logic [7:0] e;
        cs_begin();
        send_header(8'h7F);
        for (int k = 0; k < DEPTH; k++) begin
            e = exp_status();
            xfer(8'(k * 3 + 1), rx);
            chk(rx == e, "R5", "fill status", rx, e);
            if (k == DEPTH - 1) chk(rx[3:0] == 4'd1, "R6", "last fitting byte free", rx[3:0], 1);
            model.push_back(8'(k * 3 + 1));
        end
        xfer(8'hEE, rx);
        chk(rx[3:0] == 4'd0, "R7", "status when full", rx[3:0], 0);
        ovf_m = 1'b1;
        cs_end();
        chk(overflow == 1'b1, "R7", "overflow flag", overflow, 1);
        chk(pop_data == model[0], "R7", "head unchanged by dropped byte", pop_data, model[0]);
    endtask

    initial begin
        logic [2:0] states [4];
        states[0] = ST_IDLE; states[1] = ST_TX; states[2] = ST_TXUF; states[3] = 3'd4;
        void'($urandom(32'h5EED_0042));
        tick(5);
        rst_n = 1'b1;
        tick(4);
        chk(spi_miso == 1'b0, "R11", "reset miso", spi_miso, 0);
        chk(pop_valid == 1'b0, "R10", "reset pop_valid", pop_valid, 0);
        chk(overflow == 1'b0, "R7", "reset overflow", overflow, 0);

        // R1 R2: two single writes in one transaction
        single_frame(2);
        drain_check();

        // R2 R4: byte after a single write is a command; foreign commands store nothing
        cs_begin();
        send_header(8'h3F);
        send_data(8'hAA, 1'b1);
        send_header(8'h55);
        send_data(8'h66, 1'b0);
        cs_end();
        cs_begin();
        send_header(8'h3E);
        send_data(8'h11, 1'b0);
        send_data(8'h22, 1'b0);
        cs_end();
        cs_begin();
        send_header(8'hBF);
        send_data(8'h33, 1'b0);
        cs_end();
        chk(model.size() == 1, "R4", "model holds one byte", model.size(), 1);
        drain_check();

        // R3 R5: burst under a non-idle state code
        radio_state = ST_TX;
        burst_frame(10);
        drain_check();
        radio_state = ST_IDLE;

        // R6 R7 R8: fill, overflow, refused flush, accepted flush
        fill_overflow();
        radio_state = ST_TX;
        do_flush();
        chk(pop_data == model[0], "R8", "contents kept after refused flush", pop_data, model[0]);
        radio_state = ST_TXUF;
        do_flush();
        radio_state = ST_IDLE;

        // R9: sleep entry clears contents and overflow
        fill_overflow();
        radio_state = ST_SLEEP;
        tick(3);
        model.delete();
        ovf_m = 1'b0;
        chk(pop_valid == 1'b0, "R9", "empty after sleep", pop_valid, 0);
        chk(overflow == 1'b0, "R9", "overflow cleared by sleep", overflow, 0);
        radio_state = ST_IDLE;
        tick(2);
        burst_frame(3);
        drain_check();

        // Random mix of frames, pops, flushes and states
        for (int it = 0; it < 40; it++) begin
            radio_state = states[$urandom_range(0, 3)];
            case ($urandom_range(0, 3))
                0: burst_frame($urandom_range(1, 12));
                1: single_frame($urandom_range(1, 3));
                2: begin
                    int np = $urandom_range(0, 8);
                    for (int p = 0; p < np && model.size() > 0; p++) pop_one();
                end
                default: do_flush();
            endcase
            chk(overflow == ovf_m, "R7", "overflow tracking", overflow, ovf_m);
        end
        radio_state = ST_IDLE;
        drain_check();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog all requirements: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule